// File: doc/BRIEF.md
# Processor Flag Register with Flag Derivation

This block holds the eight condition flags of a small 8-bit processor core and works out their next values from what the arithmetic datapath reports. Each cycle the datapath may present two operands, the result it produced, its carry (or borrow) out and an operation class. A per-flag update mask selects which arithmetic flags that instruction is allowed to change. The block also applies interrupt-enable and interrupt-disable commands. It moves a single register bit into or out of a transfer flag, and it accepts a full-byte write of the register. The register is read back as a byte.

The sign flag is never stored on its own terms: it is always rebuilt as the exclusive-or of the negative and overflow flags. A chained subtract class (subtract-with-borrow and compare-with-borrow) only ever clears the zero flag. A multi-byte compare started on the low byte therefore ends with a zero flag that describes the whole value. Branch-condition outputs come straight from the registered flags, so a conditional branch sees the flags written by the previous instruction.

Top module: `cpu_flags`

## Requirements
- R1: A synchronous active-high reset clears all eight flags to 0x00.
- R2: Flag positions, bit 7 to bit 0, are I, T, H, S, V, N, Z, C. While op_valid is high, upd_mask bits 5, 3, 2, 1 and 0 enable updates of H, V, N, Z and C. Mask bits 7, 6 and 4 have no effect. Outside the LOGIC class, N takes the result MSB, Z is set for an all-zero result and C takes carry_out. The op_class encoding is 0 ADD, 1 SUB, 2 SUBC (chained), 3 LOGIC.
- R3: S always equals N XOR V, including after a byte write.
- R4: For ADD, H is the carry out of bit 3 and V is two's-complement add overflow. For SUB and SUBC, H is the borrow into bit 4 and V is two's-complement subtract overflow.
- R5: int_en sets I and int_dis clears I. When both are high, int_dis wins.
- R6: bit_store copies bit_src[bit_sel] into T. bld_byte equals bit_src with bit bit_sel replaced by T.
- R7: For SUBC with the Z update enabled, a nonzero result clears Z and a zero result leaves Z unchanged. C still takes carry_out.
- R8: The LOGIC class clears V and never changes H or C, whatever the mask.
- R9: br_ge is high when S is 0 and br_lt is high when S is 1. br_sh is high when C is 0 and br_lo is high when C is 1. br_take is high when flag br_sel equals br_if_set.
- R10: wr_en loads wr_data into the register and overrides every other update in the same cycle. Only bit 4 of wr_data is replaced by the derived sign.
- R11: Updates appear on sreg after the clock edge that samples them. With no operation, command or write, the register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An arithmetic or logic result is presented |
| op_class | input | 2 | 0 ADD, 1 SUB, 2 SUBC, 3 LOGIC |
| opnd_a | input | DW | First operand (destination register value) |
| opnd_b | input | DW | Second operand |
| result | input | DW | Result produced by the datapath |
| carry_out | input | 1 | Carry out of an add or borrow out of a subtract |
| upd_mask | input | 8 | Per-flag update enables in register layout |
| int_en | input | 1 | Set I |
| int_dis | input | 1 | Clear I |
| bit_store | input | 1 | Copy the selected source bit into T |
| bit_sel | input | log2(DW) | Bit index for store and load |
| bit_src | input | DW | Register value for bit store and bit load |
| bld_byte | output | DW | bit_src with the selected bit replaced by T |
| wr_en | input | 1 | Whole-register write |
| wr_data | input | 8 | Byte to write |
| br_sel | input | 3 | Flag index tested by br_take |
| br_if_set | input | 1 | Flag value that makes br_take true |
| sreg | output | 8 | Registered flag byte |
| br_take | output | 1 | Generic flag test result |
| br_ge | output | 1 | Signed greater-or-equal |
| br_lt | output | 1 | Signed less-than |
| br_sh | output | 1 | Unsigned same-or-higher |
| br_lo | output | 1 | Unsigned lower |

## Verification
Every flag lives in one register that is exposed on sreg. A wrong next-state value, such as a bad half-carry or overflow term or a zero flag set instead of kept during a chained compare, therefore shows up on sreg one cycle after the offending operation. The branch outputs reflect it in that same cycle. Corruption of the sign relation or of an unselected flag is caught at the next sample, because the bench compares the full byte each time. A wrong T value is seen both on sreg bit 6 and through bld_byte, with no extra delay.

// File: rtl/cpu_flags_pkg.sv
package cpu_flags_pkg;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'd0,
    CLS_SUB   = 2'd1,
    CLS_SUBC  = 2'd2,
    CLS_LOGIC = 2'd3
  } op_cls_t;

  localparam int FL_I = 7;
  localparam int FL_T = 6;
  localparam int FL_H = 5;
  localparam int FL_S = 4;
  localparam int FL_V = 3;
  localparam int FL_N = 2;
  localparam int FL_Z = 1;
  localparam int FL_C = 0;

  localparam logic [7:0] FLAGS_RESET = 8'h00;

endpackage

// File: rtl/flag_derive.sv
module flag_derive
  import cpu_flags_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [1:0]    cls,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] r,
  input  logic          cout,
  input  logic          z_prev,
  input  logic          h_prev,
  input  logic          c_prev,
  output logic          h_new,
  output logic          v_new,
  output logic          n_new,
  output logic          z_new,
  output logic          c_new
);
  localparam int MSB = DW - 1;
  localparam int NIB = DW / 2 - 1;

  logic a_h, b_h, r_h, a_m, b_m, r_m, r_zero;

  assign a_h    = a[NIB];
  assign b_h    = b[NIB];
  assign r_h    = r[NIB];
  assign a_m    = a[MSB];
  assign b_m    = b[MSB];
  assign r_m    = r[MSB];
  assign r_zero = ~|r;

  always_comb begin
    n_new = r_m;
    z_new = r_zero;
    c_new = cout;
    h_new = 1'b0;
    v_new = 1'b0;
    unique case (op_cls_t'(cls))
      CLS_ADD: begin
        h_new = (a_h & b_h) | (b_h & ~r_h) | (~r_h & a_h);
        v_new = (a_m & b_m & ~r_m) | (~a_m & ~b_m & r_m);
      end
      CLS_SUB, CLS_SUBC: begin
        h_new = (~a_h & b_h) | (b_h & r_h) | (r_h & ~a_h);
        v_new = (a_m & ~b_m & ~r_m) | (~a_m & b_m & r_m);
        if (op_cls_t'(cls) == CLS_SUBC) z_new = r_zero & z_prev;
      end
      default: begin
        h_new = h_prev;
        v_new = 1'b0;
        c_new = c_prev;
      end
    endcase
  end

endmodule

// File: rtl/bit_copy.sv
module bit_copy #(
  parameter int DW    = 8,
  parameter int SEL_W = $clog2(DW)
) (
  input  logic             t_flag,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    src,
  output logic             t_from_src,
  output logic [DW-1:0]    load_byte
);
  assign t_from_src = src[sel];

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign load_byte[i] = (sel == SEL_W'(i)) ? t_flag : src[i];
  end

endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import cpu_flags_pkg::*;
(
  input  logic [7:0] flags,
  input  logic [2:0] sel,
  input  logic       if_set,
  output logic       take,
  output logic       ge,
  output logic       lt,
  output logic       sh,
  output logic       lo
);
  assign take = (flags[sel] == if_set);
  assign ge   = ~flags[FL_S];
  assign lt   = flags[FL_S];
  assign sh   = ~flags[FL_C];
  assign lo   = flags[FL_C];

endmodule

// File: rtl/cpu_flags.sv
module cpu_flags
  import cpu_flags_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SEL_W = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [1:0]       op_class,
  input  logic [DW-1:0]    opnd_a,
  input  logic [DW-1:0]    opnd_b,
  input  logic [DW-1:0]    result,
  input  logic             carry_out,
  input  logic [7:0]       upd_mask,
  input  logic             int_en,
  input  logic             int_dis,
  input  logic             bit_store,
  input  logic [SEL_W-1:0] bit_sel,
  input  logic [DW-1:0]    bit_src,
  output logic [DW-1:0]    bld_byte,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [2:0]       br_sel,
  input  logic             br_if_set,
  output logic [7:0]       sreg,
  output logic             br_take,
  output logic             br_ge,
  output logic             br_lt,
  output logic             br_sh,
  output logic             br_lo
);
  logic [7:0] sreg_q, sreg_d;
  logic h_n, v_n, n_n, z_n, c_n, t_src;

  flag_derive #(.DW(DW)) u_derive (
    .cls   (op_class),
    .a     (opnd_a),
    .b     (opnd_b),
    .r     (result),
    .cout  (carry_out),
    .z_prev(sreg_q[FL_Z]),
    .h_prev(sreg_q[FL_H]),
    .c_prev(sreg_q[FL_C]),
    .h_new (h_n),
    .v_new (v_n),
    .n_new (n_n),
    .z_new (z_n),
    .c_new (c_n)
  );

  bit_copy #(.DW(DW), .SEL_W(SEL_W)) u_bits (
    .t_flag    (sreg_q[FL_T]),
    .sel       (bit_sel),
    .src       (bit_src),
    .t_from_src(t_src),
    .load_byte (bld_byte)
  );

  always_comb begin
    sreg_d = sreg_q;
    if (op_valid) begin
      if (upd_mask[FL_H]) sreg_d[FL_H] = h_n;
      if (upd_mask[FL_V]) sreg_d[FL_V] = v_n;
      if (upd_mask[FL_N]) sreg_d[FL_N] = n_n;
      if (upd_mask[FL_Z]) sreg_d[FL_Z] = z_n;
      if (upd_mask[FL_C]) sreg_d[FL_C] = c_n;
    end
    if (bit_store) sreg_d[FL_T] = t_src;
    if (int_en)    sreg_d[FL_I] = 1'b1;
    if (int_dis)   sreg_d[FL_I] = 1'b0;
    if (wr_en)     sreg_d = wr_data;
    sreg_d[FL_S] = sreg_d[FL_N] ^ sreg_d[FL_V];
  end

  always_ff @(posedge clk) begin
    if (rst) sreg_q <= FLAGS_RESET;
    else     sreg_q <= sreg_d;
  end

  assign sreg = sreg_q;

  branch_eval u_branch (
    .flags (sreg_q),
    .sel   (br_sel),
    .if_set(br_if_set),
    .take  (br_take),
    .ge    (br_ge),
    .lt    (br_lt),
    .sh    (br_sh),
    .lo    (br_lo)
  );

  // R3: sign relation kept by the register at all times
  p_sign_rel_r3: assert property (@(posedge clk) disable iff (rst)
    sreg_q[FL_S] == (sreg_q[FL_N] ^ sreg_q[FL_V]));

  // R10: byte write wins over any other update
  p_wr_override_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((sreg_q & 8'hEF) == ($past(wr_data) & 8'hEF)));

  // R5: interrupt enable and disable, disable winning
  p_int_dis_r5: assert property (@(posedge clk) disable iff (rst)
    (int_dis && !wr_en) |=> !sreg_q[FL_I]);
  p_int_en_r5: assert property (@(posedge clk) disable iff (rst)
    (int_en && !int_dis && !wr_en) |=> sreg_q[FL_I]);

  // R6: bit store reaches T
  p_bit_store_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_store && !wr_en) |=> sreg_q[FL_T] == $past(t_src));

  // R7: chained subtract only ever clears Z
  p_chain_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == CLS_SUBC && upd_mask[FL_Z] && !wr_en && result != '0)
      |=> !sreg_q[FL_Z]);
  p_chain_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == CLS_SUBC && upd_mask[FL_Z] && !wr_en && result == '0)
      |=> sreg_q[FL_Z] == $past(sreg_q[FL_Z]));

  // R8: logic class clears V and keeps H and C
  p_logic_v_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == CLS_LOGIC && !wr_en)
      |=> (sreg_q[FL_H] == $past(sreg_q[FL_H])) && (sreg_q[FL_C] == $past(sreg_q[FL_C])));

  // R11: register holds with nothing requested
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !wr_en && !int_en && !int_dis && !bit_store) |=> $stable(sreg_q));

endmodule

// File: tb/test_cpu_flags.sv
`timescale 1ns/1ps
module test_cpu_flags;
  localparam int DW = 8;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst;
  logic op_valid;
  logic [1:0] op_class;
  logic [7:0] opnd_a, opnd_b, result;
  logic carry_out;
  logic [7:0] upd_mask;
  logic int_en, int_dis, bit_store;
  logic [2:0] bit_sel;
  logic [7:0] bit_src, bld_byte;
  logic wr_en;
  logic [7:0] wr_data;
  logic [2:0] br_sel;
  logic br_if_set;
  logic [7:0] sreg;
  logic br_take, br_ge, br_lt, br_sh, br_lo;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  cpu_flags #(.DW(DW)) i_cpu_flags (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .carry_out(carry_out),
    .upd_mask(upd_mask), .int_en(int_en), .int_dis(int_dis),
    .bit_store(bit_store), .bit_sel(bit_sel), .bit_src(bit_src),
    .bld_byte(bld_byte), .wr_en(wr_en), .wr_data(wr_data),
    .br_sel(br_sel), .br_if_set(br_if_set), .sreg(sreg),
    .br_take(br_take), .br_ge(br_ge), .br_lt(br_lt), .br_sh(br_sh), .br_lo(br_lo)
  );

  // {class, a, b, result, carry, expected flags}, flags start from 0x00
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 8'h7F, 8'h01, 8'h80, 1'b0, 8'h2C},
    {2'd0, 8'hFF, 8'h01, 8'h00, 1'b1, 8'h23},
    {2'd0, 8'h80, 8'h80, 8'h00, 1'b1, 8'h1B},
    {2'd0, 8'h12, 8'h34, 8'h46, 1'b0, 8'h00},
    {2'd1, 8'h00, 8'h01, 8'hFF, 1'b1, 8'h35},
    {2'd1, 8'h80, 8'h01, 8'h7F, 1'b0, 8'h38},
    {2'd1, 8'h55, 8'h55, 8'h00, 1'b0, 8'h02},
    {2'd1, 8'h7F, 8'hFF, 8'h80, 1'b1, 8'h0D},
    {2'd3, 8'h00, 8'h00, 8'h80, 1'b0, 8'h15},
    {2'd3, 8'h00, 8'h00, 8'h00, 1'b0, 8'h03}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 0; int_en = 0; int_dis = 0; bit_store = 0; wr_en = 0;
  endtask

  task automatic do_op(input logic [1:0] c, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] r, input logic co, input logic [7:0] m);
    @(negedge clk);
    op_valid = 1; op_class = c; opnd_a = a; opnd_b = b; result = r;
    carry_out = co; upd_mask = m;
    @(posedge clk); #1 idle();
  endtask

  task automatic pulse_cmd(input logic en, input logic dis);
    @(negedge clk);
    int_en = en; int_dis = dis;
    @(posedge clk); #1 idle();
  endtask

  task automatic do_bst(input logic [2:0] s, input logic [7:0] src);
    @(negedge clk);
    bit_store = 1; bit_sel = s; bit_src = src;
    @(posedge clk); #1 idle();
  endtask

  initial begin
    #100000;
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst = 1; idle(); op_class = 0; opnd_a = 0; opnd_b = 0; result = 0;
    carry_out = 0; upd_mask = 0; bit_sel = 0; bit_src = 0; wr_data = 0;
    br_sel = 0; br_if_set = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check("R1 reset value", sreg, 8'h00);

    // R2 R4 R8 R9: vector walk
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][34:33], VEC[i][32:25], VEC[i][24:17], VEC[i][16:9], VEC[i][8], 8'h2F);
      check($sformatf("R2/R4 vector %0d flags", i), sreg, VEC[i][7:0]);
      check($sformatf("R9 vector %0d ge", i), {7'd0, br_ge}, {7'd0, ~VEC[i][4]});
      check($sformatf("R9 vector %0d sh", i), {7'd0, br_sh}, {7'd0, ~VEC[i][0]});
      check($sformatf("R9 vector %0d lt/lo", i), {6'd0, br_lt, br_lo}, {6'd0, VEC[i][4], VEC[i][0]});
    end

    // R2: empty mask and ignored mask bits
    do_op(2'd0, 8'h7F, 8'h01, 8'h80, 1'b0, 8'h00);
    check("R2 empty mask", sreg, 8'h03);
    do_op(2'd0, 8'h7F, 8'h01, 8'h80, 1'b1, 8'hD0);
    check("R2 ignored mask bits", sreg, 8'h03);

    // R5
    pulse_cmd(1, 0);
    check("R5 enable", sreg, 8'h83);
    pulse_cmd(1, 1);
    check("R5 both, disable wins", sreg, 8'h03);
    pulse_cmd(1, 0);
    pulse_cmd(0, 1);
    check("R5 disable", sreg, 8'h03);

    // R6
    do_bst(3'd3, 8'h08);
    check("R6 store one", sreg, 8'h43);
    bit_src = 8'h00; bit_sel = 3'd5; #1;
    check("R6 load one", bld_byte, 8'h20);
    do_bst(3'd3, 8'hF7);
    check("R6 store zero", sreg, 8'h03);
    bit_src = 8'hFF; bit_sel = 3'd0; #1;
    check("R6 load zero", bld_byte, 8'hFE);

    // R9 generic test
    br_sel = 3'd1; br_if_set = 1; #1;
    check("R9 take Z set", {7'd0, br_take}, 8'h01);
    br_sel = 3'd2; #1;
    check("R9 N set not taken", {7'd0, br_take}, 8'h00);
    br_if_set = 0; #1;
    check("R9 N clear taken", {7'd0, br_take}, 8'h01);

    // R7 chained compare
    do_op(2'd1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h2F);
    do_op(2'd2, 8'h01, 8'h01, 8'h00, 1'b0, 8'h2F);
    check("R7 equal chain keeps Z", sreg, 8'h02);
    do_op(2'd1, 8'h00, 8'h01, 8'hFF, 1'b1, 8'h2F);
    do_op(2'd2, 8'h01, 8'h00, 8'h00, 1'b0, 8'h2F);
    check("R7 zero high byte keeps Z clear", sreg, 8'h00);
    check("R7 same-or-higher", {7'd0, br_sh}, 8'h01);
    do_op(2'd1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h2F);
    do_op(2'd2, 8'h02, 8'h01, 8'h01, 1'b0, 8'h2F);
    check("R7 nonzero clears Z", sreg, 8'h00);

    // R10 R3
    @(negedge clk); wr_en = 1; wr_data = 8'hFF;
    @(posedge clk); #1 idle();
    check("R10 R3 write derives S", sreg, 8'hEF);
    @(negedge clk); wr_en = 1; wr_data = 8'h10; op_valid = 1; op_class = 2'd0;
    result = 8'h00; carry_out = 1; upd_mask = 8'h2F; int_en = 1; bit_store = 1;
    bit_src = 8'hFF; bit_sel = 3'd0;
    @(posedge clk); #1 idle();
    check("R10 write overrides", sreg, 8'h00);

    // R11 hold, then R1 reset mid-run
    @(negedge clk); wr_en = 1; wr_data = 8'hC3;
    @(posedge clk); #1 idle();
    repeat (3) @(posedge clk);
    #1 check("R11 hold", sreg, 8'hC3);
    @(negedge clk); rst = 1;
    @(posedge clk); #1 rst = 0;
    check("R1 reset mid-run", sreg, 8'h00);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule